// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block holds the time of day and the calendar date as seven BCD registers: seconds, minutes, hours, day of month, weekday, month and two-digit year. Each accepted one-second tick advances the seconds. A chain of carries passes each rollover up to the next field, through the hours, the day of month (with month lengths and leap years), the weekday, the month and the year. The hours can be shown in 24-hour form or in 12-hour form with an AM/PM flag. One bit of the hours register serves both forms: in 24-hour form it is the tens digit two, and in 12-hour form it is the PM marker.

Software reads any field through a combinational read port and writes any field through a one-cycle write strobe. A run bit in a control register gates the tick. The clock runs after reset, but software must load the real time and date before the values mean anything. The tick itself comes from outside, and so does any prescaling or trimming.

Top module: `rtcc_top`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour form), day 01, weekday 01, month 01, year 00, and the control register reads 1 (running).
- R2: The read port returns the field at `rd_addr`: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 weekday, 5 month, 6 year, 7 control (run flag in bit 0, other bits 0). Any other address reads 0.
- R3: Each clock cycle with `tick_1hz` high and the run flag set advances the seconds by one in BCD. A tick has no effect while the run flag (control bit 0) is 0.
- R4: Seconds roll from 59 to 00 and then advance the minutes. Minutes roll from 59 to 00 and then advance the hours.
- R5: With hours bit 7 at 0 (24-hour form), bits 5:4 hold the tens digit and bits 3:0 the units. The hours go from 23 to 00, and that step advances the day.
- R6: With hours bit 7 at 1 (12-hour form), bit 4 is the tens digit and bit 5 is 1 for PM and 0 for AM. The hours run 12, 01, ..., 11. The step from 11 to 12 flips bit 5. The step from 11 PM to 12 AM advances the day.
- R7: The day of month rolls to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and in month 02 after day 29 when the year is divisible by four and after day 28 otherwise. Each roll advances the month.
- R8: Every day advance steps the weekday, which counts from 1 to 7 and returns to 1.
- R9: The month rolls from 12 to 01 and advances the year. The year rolls from 99 to 00.
- R10: A write to a field in the same cycle as an accepted tick stores the written value in that field. The other fields still advance as the tick requires.
- R11: A write to the hours stores bits 7, 5, 4 and 3:0, and bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Field written when `wr_en` is high |
| wr_data | input | 8 | Write value |
| rd_addr | input | ADDR_W | Field read |
| rd_data | output | 8 | Value of the addressed field |

## Verification
The carry chain is driven from three kinds of starting point. Plain ticks in mid-range values show single-digit stepping and the effect of the run gate. Loaded end-of-day values (23:59:59, and 11:59:59 in both AM and PM) show where each form of the hour wraps and when the day advances. End-of-month dates in short, long and February months, in leap and non-leap years, show that the day limit follows both the month and the year. A write landing in a tick cycle shows that the written field wins while a neighbouring field keeps advancing.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

   typedef enum logic [2:0] {
      F_SEC   = 3'd0,
      F_MIN   = 3'd1,
      F_HOUR  = 3'd2,
      F_DATE  = 3'd3,
      F_WDAY  = 3'd4,
      F_MONTH = 3'd5,
      F_YEAR  = 3'd6,
      F_CTRL  = 3'd7
   } rtcc_field_e;

   // next value of a two-digit BCD number, no wrap handling
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
      else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
   endfunction

   // two-digit BCD year divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) bcd_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      bcd_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   // last day of a BCD month
   function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      month_last = bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
         default:                    month_last = 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtcc_bcd_field.sv
module rtcc_bcd_field #(
   parameter logic [7:0] FIRST     = 8'h00,
   parameter logic [7:0] RESET_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic [7:0] last,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] q,
   output logic       wrap
);
   import rtcc_pkg::*;

   assign wrap = step && (q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_VAL;
      else if (ld)   q <= ld_val;
      else if (wrap) q <= FIRST;
      else if (step) q <= bcd_inc(q);
   end
endmodule

// File: rtl/rtcc_hour_ctr.sv
module rtcc_hour_ctr #(
   parameter logic [7:0] RESET_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] q,
   output logic       wrap
);
   import rtcc_pkg::*;

   logic [7:0] nxt;
   logic [7:0] h;
   logic [7:0] hi;
   logic       day_end;

   always_comb begin
      nxt     = q;
      day_end = 1'b0;
      if (q[7]) begin
         h  = {3'b000, q[4:0]};
         hi = bcd_inc(h);
         if (h == 8'h12) begin
            nxt = {1'b1, 1'b0, q[5], 5'h01};
         end else if (h == 8'h11) begin
            nxt     = {1'b1, 1'b0, ~q[5], 5'h12};
            day_end = q[5];
         end else begin
            nxt = {1'b1, 1'b0, q[5], hi[4:0]};
         end
      end else begin
         h  = {2'b00, q[5:0]};
         hi = bcd_inc(h);
         if (h == 8'h23) begin
            nxt     = 8'h00;
            day_end = 1'b1;
         end else begin
            nxt = {2'b00, hi[5:0]};
         end
      end
   end

   assign wrap = step && day_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_VAL;
      else if (ld)   q <= ld_val & 8'hBF;
      else if (step) q <= nxt;
   end
endmodule

// File: rtl/rtcc_top.sv
module rtcc_top #(
   parameter int         ADDR_W       = 3,
   parameter bit         RUN_AT_RESET = 1'b1,
   parameter logic [7:0] YEAR_RESET   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   import rtcc_pkg::*;

   localparam int NUM_MS = 2;   // seconds and minutes share one shape

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("rtcc_top: ADDR_W must be at least 3");
      end
      if (YEAR_RESET[3:0] > 4'd9 || YEAR_RESET[7:4] > 4'd9) begin : g_bad_year
         $error("rtcc_top: YEAR_RESET must be BCD");
      end
   endgenerate

   logic              run_q;
   logic              adv;
   logic [NUM_MS:0]   ms_step;
   logic [7:0]        ms_q [NUM_MS];
   logic [7:0]        sec_q, min_q, hour_q, date_q, wday_q, month_q, year_q;
   logic              day_step, month_step, year_step, wday_wrap, year_wrap;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input rtcc_field_e f);
      hit = wr_en && (a == ADDR_W'(f));
   endfunction

   assign adv        = tick_1hz && run_q;
   assign ms_step[0] = adv;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_MS; gi++) begin : g_ms
         rtcc_bcd_field #(.FIRST(8'h00), .RESET_VAL(8'h00)) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (ms_step[gi]),
            .last   (8'h59),
            .ld     (wr_en && (wr_addr == ADDR_W'(gi))),
            .ld_val (wr_data),
            .q      (ms_q[gi]),
            .wrap   (ms_step[gi+1])
         );
      end
   endgenerate

   assign sec_q = ms_q[0];
   assign min_q = ms_q[1];

   rtcc_hour_ctr #(.RESET_VAL(8'h00)) u_hour (
      .clk (clk), .rst_n (rst_n), .step (ms_step[NUM_MS]),
      .ld (hit(wr_addr, F_HOUR)), .ld_val (wr_data),
      .q (hour_q), .wrap (day_step)
   );

   rtcc_bcd_field #(.FIRST(8'h01), .RESET_VAL(8'h01)) u_date (
      .clk (clk), .rst_n (rst_n), .step (day_step),
      .last (month_last(month_q, year_q)),
      .ld (hit(wr_addr, F_DATE)), .ld_val (wr_data),
      .q (date_q), .wrap (month_step)
   );

   rtcc_bcd_field #(.FIRST(8'h01), .RESET_VAL(8'h01)) u_wday (
      .clk (clk), .rst_n (rst_n), .step (day_step), .last (8'h07),
      .ld (hit(wr_addr, F_WDAY)), .ld_val (wr_data),
      .q (wday_q), .wrap (wday_wrap)
   );

   rtcc_bcd_field #(.FIRST(8'h01), .RESET_VAL(8'h01)) u_month (
      .clk (clk), .rst_n (rst_n), .step (month_step), .last (8'h12),
      .ld (hit(wr_addr, F_MONTH)), .ld_val (wr_data),
      .q (month_q), .wrap (year_step)
   );

   rtcc_bcd_field #(.FIRST(8'h00), .RESET_VAL(YEAR_RESET)) u_year (
      .clk (clk), .rst_n (rst_n), .step (year_step), .last (8'h99),
      .ld (hit(wr_addr, F_YEAR)), .ld_val (wr_data),
      .q (year_q), .wrap (year_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run_q <= RUN_AT_RESET;
      else if (hit(wr_addr, F_CTRL))  run_q <= wr_data[0];
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd_addr == ADDR_W'(F_SEC))   rd_data = sec_q;
      if (rd_addr == ADDR_W'(F_MIN))   rd_data = min_q;
      if (rd_addr == ADDR_W'(F_HOUR))  rd_data = hour_q;
      if (rd_addr == ADDR_W'(F_DATE))  rd_data = date_q;
      if (rd_addr == ADDR_W'(F_WDAY))  rd_data = wday_q;
      if (rd_addr == ADDR_W'(F_MONTH)) rd_data = month_q;
      if (rd_addr == ADDR_W'(F_YEAR))  rd_data = year_q;
      if (rd_addr == ADDR_W'(F_CTRL))  rd_data = {7'd0, run_q};
   end
endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              run,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        sec,
   input logic [7:0]        hour
);
   logic wr_sec, wr_hour;
   assign wr_sec  = wr_en && (wr_addr == ADDR_W'(0));
   assign wr_hour = wr_en && (wr_addr == ADDR_W'(2));

   assert_sec_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec[3:0] <= 4'd9) && (sec <= 8'h59));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && run) && !wr_sec) |=> $stable(sec));

   assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && sec == 8'h59 && !wr_sec) |=> (sec == 8'h00));

   assert_wr_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sec |=> (sec == $past(wr_data)));

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hour |=> $stable(hour[7]));

   assert_hour_bit6_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hour[6] == 1'b0);
endmodule

bind rtcc_top rtcc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_1hz),
   .run     (run_q),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .sec     (sec_q),
   .hour    (hour_q)
);

// File: tb/rtcc_top_tb_top.sv
`timescale 1ns/1ps
module rtcc_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtcc_top dut_i (
      .clk (clk), .rst_n (rst_n), .tick_1hz (tick_1hz),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_addr (rd_addr), .rd_data (rd_data)
   );

   task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s addr %0d got %h expected %h", req, a, rd_data, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_1hz = 1'b1;
         @(negedge clk);
         tick_1hz = 1'b0;
      end
   endtask

   task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                       input logic [7:0] d, input logic [7:0] w, input logic [7:0] mo,
                       input logic [7:0] y);
      wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, w); wr(5, mo); wr(6, y);
   endtask

   task automatic t_reset;
      expect_rd("R1", 0, 8'h00); expect_rd("R1", 1, 8'h00);
      expect_rd("R1", 2, 8'h00); expect_rd("R1", 3, 8'h01);
      expect_rd("R1", 4, 8'h01); expect_rd("R1", 5, 8'h01);
      expect_rd("R1", 6, 8'h00); expect_rd("R2", 7, 8'h01);
   endtask

   task automatic t_run_gate;
      ticks(3);
      expect_rd("R3", 0, 8'h03);
      wr(7, 8'h00);
      expect_rd("R2", 7, 8'h00);
      ticks(2);
      expect_rd("R3", 0, 8'h03);
      wr(7, 8'h01);
      ticks(7);
      expect_rd("R3", 0, 8'h10);
   endtask

   task automatic t_24h_rollover;
      load(8'h59, 8'h59, 8'h23, 8'h31, 8'h07, 8'h12, 8'h99);
      ticks(1);
      expect_rd("R4", 0, 8'h00); expect_rd("R4", 1, 8'h00);
      expect_rd("R5", 2, 8'h00); expect_rd("R7", 3, 8'h01);
      expect_rd("R8", 4, 8'h01); expect_rd("R9", 5, 8'h01);
      expect_rd("R9", 6, 8'h00);
      load(8'h59, 8'h59, 8'h19, 8'h10, 8'h03, 8'h06, 8'h10);
      ticks(1);
      expect_rd("R5", 2, 8'h20); expect_rd("R5", 3, 8'h10);
   endtask

   task automatic t_12h;
      load(8'h59, 8'h59, 8'h91, 8'h05, 8'h02, 8'h03, 8'h21);
      ticks(1);
      expect_rd("R6", 2, 8'hB2); expect_rd("R6", 3, 8'h05);
      load(8'h59, 8'h59, 8'hB2, 8'h05, 8'h02, 8'h03, 8'h21);
      ticks(1);
      expect_rd("R6", 2, 8'hA1);
      load(8'h59, 8'h59, 8'h89, 8'h05, 8'h02, 8'h03, 8'h21);
      ticks(1);
      expect_rd("R6", 2, 8'h90);
      load(8'h59, 8'h59, 8'hB1, 8'h05, 8'h02, 8'h03, 8'h21);
      ticks(1);
      expect_rd("R6", 2, 8'h92); expect_rd("R6", 3, 8'h06);
      expect_rd("R8", 4, 8'h03);
   endtask

   task automatic t_months;
      load(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h24);
      ticks(1);
      expect_rd("R7", 3, 8'h29); expect_rd("R7", 5, 8'h02);
      load(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h24);
      ticks(1);
      expect_rd("R7", 3, 8'h01); expect_rd("R7", 5, 8'h03);
      load(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
      ticks(1);
      expect_rd("R7", 3, 8'h01); expect_rd("R7", 5, 8'h03);
      load(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h23);
      ticks(1);
      expect_rd("R7", 3, 8'h01); expect_rd("R7", 5, 8'h05);
      load(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h01, 8'h23);
      ticks(1);
      expect_rd("R7", 3, 8'h31); expect_rd("R7", 5, 8'h01);
      load(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h12, 8'h41);
      ticks(1);
      expect_rd("R9", 6, 8'h42); expect_rd("R8", 4, 8'h06);
   endtask

   task automatic t_priority;
      load(8'h59, 8'h10, 8'h05, 8'h12, 8'h01, 8'h07, 8'h30);
      @(negedge clk);
      tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h42;
      @(negedge clk);
      tick_1hz = 1'b0; wr_en = 1'b0;
      expect_rd("R10", 1, 8'h42); expect_rd("R10", 0, 8'h00);
      @(negedge clk);
      tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
      @(negedge clk);
      tick_1hz = 1'b0; wr_en = 1'b0;
      expect_rd("R10", 0, 8'h30); expect_rd("R10", 1, 8'h42);
   endtask

   task automatic t_hour_mask;
      wr(2, 8'h52);
      expect_rd("R11", 2, 8'h12);
      wr(2, 8'hC7);
      expect_rd("R11", 2, 8'h87);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run_gate();
      t_24h_rollover();
      t_12h();
      t_months();
      t_priority();
      t_hour_mask();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule